// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Slave

This block models the device side of a three-wire serial EEPROM. A host drives chip select, a serial clock and a serial data line. The block drives one data-out line with a separate output enable, so high impedance can be modelled on a shared pin. All three inputs are synchronised to a fast system clock, and every rising serial-clock edge is found by edge detection. The block holds 64 words of 16 bits.

A command begins with a start bit. A 2-bit opcode and a 6-bit address follow, sent most significant bit first. Read, write, write-enable and write-disable commands are decoded. Writes are gated by a write-enable latch, which reset clears. A write is committed only when chip select falls after a complete frame. Programming then runs for a parameterised number of system clocks. During that time the block is busy and shows its state on the data-out line whenever chip select is high.

Top module: `uwire_eeprom_slave`

## Requirements
- R1: After reset, data-out is released (output enable low) and the write-enable latch is clear, so a complete write frame followed by chip-select low starts no programming.
- R2: A write-enable command (opcode 00, A5:A4 = 11) sets the latch, and it stays set across any number of writes and reads.
- R3: A write-disable command (opcode 00, A5:A4 = 00) clears the latch, and later write frames leave the memory unchanged.
- R4: A read (opcode 10) drives a 0 after the A0 edge, then D15 down to D0 on the next 16 rising serial-clock edges. It works with the latch either set or clear.
- R5: A write (opcode 01) takes 6 address bits (A5 first) and 16 data bits (D15 first), with D0 on the 25th rising edge counted from the start bit. The word is stored only after chip select falls.
- R6: If chip select falls before D0 has been captured, the frame is discarded: no busy period and no memory change.
- R7: While programming, raising chip select makes data-out drive 0. Once TWRITE_CYCLES system clocks have passed, data-out drives 1.
- R8: While busy, serial-clock and data activity is ignored, so a write-disable sent during busy has no effect.
- R9: With chip select low, the output enable is low, including when chip select drops in the middle of a read.
- R10: Zeros clocked before the first 1 with chip select high are skipped, and that first 1 is taken as the start bit.
- R11: Opcodes are decoded as read = 10, write = 01 and extended = 00. Inside the extended group, A5:A4 selects enable (11) or disable (00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from host |
| di_i | input | 1 | Serial data from host |
| do_o | output | 1 | Serial data / status to host |
| do_oe_o | output | 1 | Output enable for do_o (0 = high impedance) |

## Verification
The bench builds the block with TWRITE_CYCLES = 300 and the default 6-bit address and 16-bit data widths. A programming window of 300 clocks is long enough that a complete nine-edge command frame can be clocked in while the block is still busy, which tests the ignore-while-busy rule. It is also short enough that the busy-to-ready transition can be waited out and checked many times. Every half period of the serial clock lasts six system clocks, so each data-out value is sampled after the synchroniser and the edge-detect latency have settled.

// File: rtl/uwe_pkg.sv
`timescale 1ns/1ps
package uwe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_WFULL,
    ST_SKIP,
    ST_READ,
    ST_BUSY,
    ST_READY
  } eng_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [1:0] EXT_ENABLE  = 2'b11;
  localparam logic [1:0] EXT_DISABLE = 2'b00;

endpackage

// File: rtl/uwe_pin_sync.sv
`timescale 1ns/1ps
module uwe_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic rst_sync_n,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise
);

  localparam int NPINS = 3;

  logic [STAGES-1:0] rst_pipe_q;
  logic [NPINS-1:0]  pins_raw;
  logic [NPINS-1:0]  pins_s;
  logic              sk_prev_q;

  assign pins_raw = {cs_i, sk_i, di_i};

  // reset: asserted asynchronously, released through the pipe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[STAGES-1];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-2:0], pins_raw[p]};
    end
    assign pins_s[p] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_prev_q <= 1'b0;
    else        sk_prev_q <= pins_s[1];
  end

  assign cs_s    = pins_s[2];
  assign di_s    = pins_s[0];
  assign sk_rise = pins_s[1] & ~sk_prev_q;

endmodule

// File: rtl/uwe_word_store.sv
`timescale 1ns/1ps
module uwe_word_store #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/uwe_cmd_engine.sv
`timescale 1ns/1ps
module uwe_cmd_engine
  import uwe_pkg::*;
#(
  parameter int AW            = 6,
  parameter int DW            = 16,
  parameter int TWRITE_CYCLES = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          di_s,
  input  logic          sk_rise,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          do_o,
  output logic          do_oe_o
);

  localparam int CNT_W = $clog2(TWRITE_CYCLES + 1);
  localparam int BIT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] TW_LOAD = CNT_W'(TWRITE_CYCLES - 1);
  localparam logic [BIT_W-1:0] OPC_LAST  = BIT_W'(1);
  localparam logic [BIT_W-1:0] ADDR_LAST = BIT_W'(AW - 1);
  localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(DW - 1);

  eng_state_e        st_q, st_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [1:0]        opc_q, opc_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [DW-1:0]     sh_q, sh_d;
  logic              wen_q, wen_d;
  logic [CNT_W-1:0]  tw_q, tw_d;
  logic              dout_q, dout_d;
  logic [AW-1:0]     addr_shift;

  assign addr_shift = {addr_q[AW-2:0], di_s};
  assign rd_addr    = addr_shift;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    opc_d  = opc_q;
    addr_d = addr_q;
    sh_d   = sh_q;
    wen_d  = wen_q;
    tw_d   = tw_q;
    dout_d = dout_q;
    mem_we = 1'b0;
    if (st_q == ST_BUSY) begin
      if (tw_q == '0) begin
        mem_we = 1'b1;
        st_d   = cs_s ? ST_READY : ST_IDLE;
      end else begin
        tw_d = tw_q - 1'b1;
      end
    end else if (!cs_s) begin
      if (st_q == ST_WFULL && wen_q) begin
        st_d = ST_BUSY;
        tw_d = TW_LOAD;
      end else begin
        st_d = ST_IDLE;
      end
    end else if (sk_rise) begin
      case (st_q)
        ST_IDLE, ST_READY: begin
          if (di_s) begin
            st_d  = ST_OPC;
            bit_d = '0;
          end
        end
        ST_OPC: begin
          opc_d = {opc_q[0], di_s};
          bit_d = bit_q + 1'b1;
          if (bit_q == OPC_LAST) begin
            st_d  = ST_ADDR;
            bit_d = '0;
          end
        end
        ST_ADDR: begin
          addr_d = addr_shift;
          bit_d  = bit_q + 1'b1;
          if (bit_q == ADDR_LAST) begin
            bit_d = '0;
            case (opc_q)
              OP_READ: begin
                st_d   = ST_READ;
                sh_d   = rd_data;
                dout_d = 1'b0;
              end
              OP_WRITE: st_d = ST_DATA;
              OP_EXT: begin
                if (addr_shift[AW-1 -: 2] == EXT_ENABLE)       wen_d = 1'b1;
                else if (addr_shift[AW-1 -: 2] == EXT_DISABLE) wen_d = 1'b0;
                st_d = ST_SKIP;
              end
              default: st_d = ST_SKIP;
            endcase
          end
        end
        ST_DATA: begin
          sh_d  = {sh_q[DW-2:0], di_s};
          bit_d = bit_q + 1'b1;
          if (bit_q == DATA_LAST) st_d = ST_WFULL;
        end
        ST_READ: begin
          dout_d = sh_q[DW-1];
          sh_d   = {sh_q[DW-2:0], 1'b0};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      opc_q  <= '0;
      addr_q <= '0;
      sh_q   <= '0;
      wen_q  <= 1'b0;
      tw_q   <= '0;
      dout_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      opc_q  <= opc_d;
      addr_q <= addr_d;
      sh_q   <= sh_d;
      wen_q  <= wen_d;
      tw_q   <= tw_d;
      dout_q <= dout_d;
    end
  end

  assign mem_waddr = addr_q;
  assign mem_wdata = sh_q;
  assign do_oe_o   = cs_s & ((st_q == ST_READ) | (st_q == ST_BUSY) | (st_q == ST_READY));
  assign do_o      = (st_q == ST_READ) ? dout_q : (st_q == ST_READY);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY && tw_q != '0) |=> (st_q == ST_BUSY));

  // R2
  wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wen_q);

  // R2
  wen_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sk_rise |=> $stable(wen_q));

  // R5
  commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WFULL && !cs_s && wen_q) |=> (st_q == ST_BUSY));

  // R6
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && !cs_s) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/uwire_eeprom_slave.sv
`timescale 1ns/1ps
module uwire_eeprom_slave #(
  parameter int ADDR_BITS     = 6,
  parameter int DATA_BITS     = 16,
  parameter int TWRITE_CYCLES = 20000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);

  logic                 rst_sync_n;
  logic                 cs_s;
  logic                 di_s;
  logic                 sk_rise;
  logic [ADDR_BITS-1:0] rd_addr;
  logic [DATA_BITS-1:0] rd_data;
  logic                 mem_we;
  logic [ADDR_BITS-1:0] mem_waddr;
  logic [DATA_BITS-1:0] mem_wdata;

  uwe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_i       (cs_i),
    .sk_i       (sk_i),
    .di_i       (di_i),
    .rst_sync_n (rst_sync_n),
    .cs_s       (cs_s),
    .di_s       (di_s),
    .sk_rise    (sk_rise)
  );

  uwe_cmd_engine #(
    .AW            (ADDR_BITS),
    .DW            (DATA_BITS),
    .TWRITE_CYCLES (TWRITE_CYCLES)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_s      (cs_s),
    .di_s      (di_s),
    .sk_rise   (sk_rise),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .do_o      (do_o),
    .do_oe_o   (do_oe_o)
  );

  uwe_word_store #(.AW(ADDR_BITS), .DW(DATA_BITS)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R9
  cs_low_hiz_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cs_s |-> !do_oe_o);

endmodule

// File: tb/uwire_eeprom_slave_tb.sv
`timescale 1ns/1ps
module uwire_eeprom_slave_tb;

  localparam int TW   = 300;
  localparam int HALF = 6;
  localparam int NVEC = 11;

  // vector: [39:38] action (0 enable, 1 write, 2 read, 3 disable), [37:32] address,
  //         [31:16] write data, [15:0] expected read data
  localparam logic [39:0] VEC [NVEC] = '{
    {2'd0, 6'h00, 16'h0000, 16'h0000},
    {2'd1, 6'h03, 16'hA5C3, 16'h0000},
    {2'd2, 6'h03, 16'h0000, 16'hA5C3},
    {2'd1, 6'h3F, 16'hFFFF, 16'h0000},
    {2'd2, 6'h3F, 16'h0000, 16'hFFFF},
    {2'd1, 6'h00, 16'h0001, 16'h0000},
    {2'd2, 6'h00, 16'h0000, 16'h0001},
    {2'd3, 6'h00, 16'h0000, 16'h0000},
    {2'd1, 6'h03, 16'h1234, 16'h0000},
    {2'd2, 6'h03, 16'h0000, 16'hA5C3},
    {2'd2, 6'h00, 16'h0000, 16'h0001}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cs, sk, di;
  logic dout, doe;
  int   total = 0;
  int   fails = 0;
  bit   wen_m = 1'b0;

  always #2 clk = ~clk;

  uwire_eeprom_slave #(.TWRITE_CYCLES(TW)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_i    (cs),
    .sk_i    (sk),
    .di_i    (di),
    .do_o    (dout),
    .do_oe_o (doe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic b, output logic so, output logic soe);
    di = b;
    tick(HALF);
    sk = 1'b1;
    tick(HALF);
    so  = dout;
    soe = doe;
    sk  = 1'b0;
  endtask

  task automatic send_head(input logic [1:0] op, input logic [5:0] addr, output logic so, output logic soe);
    pulse(1'b1, so, soe);
    for (int i = 0; i < 2; i++) pulse(op[1-i], so, soe);
    for (int i = 0; i < 6; i++) pulse(addr[5-i], so, soe);
  endtask

  task automatic do_read(input logic [5:0] addr, input int lead, output logic [15:0] val, output bit dummy_ok);
    logic so, soe;
    cs = 1'b1;
    tick(4);
    for (int i = 0; i < lead; i++) pulse(1'b0, so, soe);
    send_head(2'b10, addr, so, soe);
    dummy_ok = soe && !so;
    val = '0;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0, so, soe);
      val = {val[14:0], so};
    end
    cs = 1'b0;
    tick(HALF);
  endtask

  task automatic do_write(input logic [5:0] addr, input logic [15:0] data, input int nbits);
    logic so, soe;
    cs = 1'b1;
    tick(4);
    send_head(2'b01, addr, so, soe);
    for (int i = 0; i < nbits; i++) pulse(data[15-i], so, soe);
    cs = 1'b0;
    tick(HALF);
  endtask

  task automatic do_ext(input logic [1:0] sel);
    logic so, soe;
    cs = 1'b1;
    tick(4);
    send_head(2'b00, {sel, 4'b0000}, so, soe);
    cs = 1'b0;
    tick(HALF);
  endtask

  task automatic status(input bit expect_busy, input string tag);
    int n;
    cs = 1'b1;
    tick(4);
    if (expect_busy) begin
      check(doe && !dout, {tag, " busy shows 0"}, {30'd0, doe, dout}, 32'h2);
      n = 0;
      while (!dout && n < TW + 100) begin
        tick(1);
        n++;
      end
      check(dout && doe && n > TW / 2, {tag, " ready after programming time"}, n, TW);
    end else begin
      check(!doe, {tag, " no busy period"}, {31'd0, doe}, 32'h0);
    end
    cs = 1'b0;
    tick(HALF);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] val;
    bit          dok;
    logic        so, soe;
    cs = 1'b0; sk = 1'b0; di = 1'b0;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(6);

    // R1 / R9: released pin after reset, also with CS high and idle
    check(!doe, "R1 reset oe low", {31'd0, doe}, 32'h0);
    cs = 1'b1; tick(6);
    check(!doe, "R9 idle cs high oe low", {31'd0, doe}, 32'h0);
    cs = 1'b0; tick(6);

    // R1: write before any enable starts nothing
    do_write(6'h05, 16'hBEEF, 16);
    status(1'b0, "R1");

    // table walk: R2 R3 R4 R5 R7 R11
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][39:38])
        2'd0: begin do_ext(2'b11); wen_m = 1'b1; end
        2'd3: begin do_ext(2'b00); wen_m = 1'b0; end
        2'd1: begin
          do_write(VEC[i][37:32], VEC[i][31:16], 16);
          status(wen_m, wen_m ? "R5 R7 R2" : "R3");
        end
        default: begin
          do_read(VEC[i][37:32], 0, val, dok);
          check(dok, "R4 dummy zero after A0", {31'd0, dok}, 32'h1);
          check(val == VEC[i][15:0], "R4 R11 read data", val, VEC[i][15:0]);
        end
      endcase
    end

    // R10: leading zeros before the start bit
    do_read(6'h3F, 3, val, dok);
    check(val == 16'hFFFF && dok, "R10 leading zeros skipped", val, 16'hFFFF);

    // R6: frame cut short after ten data bits
    do_ext(2'b11);
    do_write(6'h03, 16'h1234, 10);
    status(1'b0, "R6");
    do_read(6'h03, 0, val, dok);
    check(val == 16'hA5C3, "R6 memory unchanged", val, 16'hA5C3);

    // R8: disable command sent while busy is ignored
    do_write(6'h0A, 16'h5A5A, 16);
    cs = 1'b1; tick(4);
    check(doe && !dout, "R8 busy before frame", {30'd0, doe, dout}, 32'h2);
    send_head(2'b00, 6'h00, so, soe);
    check(soe && !so, "R8 still busy during frame", {30'd0, soe, so}, 32'h2);
    cs = 1'b0; tick(HALF);
    status(1'b1, "R8 finish");
    do_write(6'h0B, 16'hC3C3, 16);
    status(1'b1, "R8 enable survived");
    do_read(6'h0B, 0, val, dok);
    check(val == 16'hC3C3, "R8 write after ignored disable", val, 16'hC3C3);
    do_read(6'h0A, 0, val, dok);
    check(val == 16'h5A5A, "R5 busy write committed", val, 16'h5A5A);

    // R9: chip select dropped mid-read releases the pin
    cs = 1'b1; tick(4);
    send_head(2'b10, 6'h0B, so, soe);
    for (int i = 0; i < 4; i++) pulse(1'b0, so, soe);
    check(soe, "R9 driving during read", {31'd0, soe}, 32'h1);
    cs = 1'b0; tick(5);
    check(!doe, "R9 oe low after cs drop", {31'd0, doe}, 32'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule